// File: doc/BRIEF.md
# Cross-Domain Peripheral Control Register

This block is an 8-bit control register written from a bus clock domain. It drives a peripheral that runs in a second, unrelated core clock domain. It holds three fields: a clock-select choice, an enable and a software-reset trigger. The clock-select field acts in the bus domain straight away. The enable and software-reset fields are carried into the core domain by a toggle handshake. A read-only status word reports each hand-over that is still in flight.

Software writes the control word and reads it back. A written enable value reads back on the next bus cycle. Software then polls the status word until the matching busy flag drops. When the enable flag drops, the core domain holds the new value. A software-reset write discards the other fields of that same write and emits one reset pulse in the core domain. When the reset finishes, every field returns to zero. A write-protect input blocks all writes. The clock-select field is protected by the enable: it can change only while the block reads as disabled.

Top module: `ctrl_sync_reg`

## Requirements
- R1: After hardware reset, ctrl_o, status_o, clksel_o, core_en_o and core_rst_o are all 0.
- R2: In ctrl_o, bit 4 is the clock select, bit 1 is the enable and bit 0 is the software reset. Bits 7, 6, 5, 3 and 2 ignore writes and always read 0.
- R3: A write with bit 0 clear and no enable hand-over pending sets ctrl_o bit 1 to the written value on the next bus cycle. The same write sets status_o bit 1 on the next bus cycle.
- R4: core_en_o takes the written enable value after the crossing into the core domain. status_o bit 1 then clears within 20 bus cycles of the write.
- R5: An enable write made while status_o bit 1 is set is ignored.
- R6: clksel_o and ctrl_o bit 4 follow a write on the next bus cycle, but only while ctrl_o bit 1 reads 0. Otherwise the clock-select write is ignored. Value 0 selects the fast clock used for filtering above 32 kHz; value 1 selects the low-power 32 kHz clock.
- R7: A write with bit 0 set discards the clock-select and enable values of that write. It sets ctrl_o bit 0 and status_o bit 0, and both stay 1 until the reset completes, then clear on the same cycle. A write with bit 0 clear never sets ctrl_o bit 0.
- R8: A software reset produces exactly one core_rst_o pulse, one core cycle wide. It leaves core_en_o at 0 and ctrl_o at 0 when it completes.
- R9: Writes made while a software reset is in progress are ignored.
- R10: While wprot_i is 1, every write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Bus-domain asynchronous reset, active low |
| core_clk_i | input | 1 | Core clock |
| core_rst_ni | input | 1 | Core-domain asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wprot_i | input | 1 | Write protect; blocks every write |
| wdata_i | input | 8 | Write data |
| ctrl_o | output | 8 | Control word read-back |
| status_o | output | 8 | Busy flags: bit 0 reset, bit 1 enable |
| clksel_o | output | 1 | Selected clock source, 0 fast, 1 low-power 32 kHz |
| core_en_o | output | 1 | Enable in the core domain |
| core_rst_o | output | 1 | One-cycle reset pulse in the core domain |

## Verification
The bus-domain results (read-back, clock select and the rise of the busy flags) are registered once, so they are due one bus cycle after the capturing edge. The bench samples them at the falling edge that follows the write. The crossing results depend on the phase between the two clocks, so the bench polls the status word at each falling bus edge against a fixed bound. It then checks core_en_o and the count and width of the reset pulses once the busy flag has dropped. At every poll during a software reset, the bench compares ctrl_o bit 0 with status_o bit 0 to confirm that the two clear together.

// File: rtl/ctrl_sync_pkg.sv
`timescale 1ns/1ps
package ctrl_sync_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned BIT_SWRST = 0;
  localparam int unsigned BIT_EN    = 1;
  localparam int unsigned BIT_CKSEL = 4;

  typedef enum logic {
    CLK_FAST    = 1'b0,
    CLK_LP_32K  = 1'b1
  } clk_src_e;
endpackage

// File: rtl/ctrl_sync_ff.sv
`timescale 1ns/1ps
module ctrl_sync_ff #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ctrl_sync_hs.sv
`timescale 1ns/1ps
module ctrl_sync_hs #(
  parameter int unsigned STAGES = 2
) (
  input  logic src_clk_i,
  input  logic src_rst_ni,
  input  logic req_i,
  output logic busy_o,
  input  logic dst_clk_i,
  input  logic dst_rst_ni,
  output logic evt_o
);
  logic req_tgl_q, ack_tgl_q, req_s, ack_s;

  always_ff @(posedge src_clk_i or negedge src_rst_ni)
    if (!src_rst_ni)  req_tgl_q <= 1'b0;
    else if (req_i)   req_tgl_q <= ~req_tgl_q;

  ctrl_sync_ff #(.STAGES(STAGES)) i_req_sync (
    .clk_i(dst_clk_i), .rst_ni(dst_rst_ni), .d_i(req_tgl_q), .q_o(req_s)
  );

  assign evt_o = req_s ^ ack_tgl_q;

  always_ff @(posedge dst_clk_i or negedge dst_rst_ni)
    if (!dst_rst_ni) ack_tgl_q <= 1'b0;
    else if (evt_o)  ack_tgl_q <= req_s;

  ctrl_sync_ff #(.STAGES(STAGES)) i_ack_sync (
    .clk_i(src_clk_i), .rst_ni(src_rst_ni), .d_i(ack_tgl_q), .q_o(ack_s)
  );

  assign busy_o = req_tgl_q ^ ack_s;

  // New request only when the previous one is acknowledged (R5)
  assert_no_req_while_busy_R5: assert property (
    @(posedge src_clk_i) disable iff (!src_rst_ni) req_i |-> !busy_o);

  // Each request yields one single-cycle event (R8)
  assert_evt_one_cycle_R8: assert property (
    @(posedge dst_clk_i) disable iff (!dst_rst_ni) evt_o |=> !evt_o);
endmodule

// File: rtl/ctrl_sync_reg.sv
`timescale 1ns/1ps
module ctrl_sync_reg
  import ctrl_sync_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             core_clk_i,
  input  logic             core_rst_ni,
  input  logic             wr_en_i,
  input  logic             wprot_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ctrl_o,
  output logic [REG_W-1:0] status_o,
  output logic             clksel_o,
  output logic             core_en_o,
  output logic             core_rst_o
);
  logic     swrst_q, en_q;
  clk_src_e clksel_q;
  logic     en_busy, sw_busy, en_evt, sw_evt, core_en_q;
  logic     wr_ok, sw_req, en_req, ck_wr, sw_done;

  assign wr_ok   = wr_en_i & ~wprot_i & ~swrst_q;
  assign sw_req  = wr_ok &  wdata_i[BIT_SWRST];
  assign en_req  = wr_ok & ~wdata_i[BIT_SWRST] & ~en_busy;
  assign ck_wr   = wr_ok & ~wdata_i[BIT_SWRST] & ~en_q;
  assign sw_done = swrst_q & ~sw_busy;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      swrst_q  <= 1'b0;
      en_q     <= 1'b0;
      clksel_q <= CLK_FAST;
    end else if (sw_done) begin
      swrst_q  <= 1'b0;
      en_q     <= 1'b0;
      clksel_q <= CLK_FAST;
    end else begin
      if (sw_req) swrst_q  <= 1'b1;
      if (en_req) en_q     <= wdata_i[BIT_EN];
      if (ck_wr)  clksel_q <= clk_src_e'(wdata_i[BIT_CKSEL]);
    end

  ctrl_sync_hs #(.STAGES(SYNC_STAGES)) i_hs_en (
    .src_clk_i(clk_i), .src_rst_ni(rst_ni), .req_i(en_req), .busy_o(en_busy),
    .dst_clk_i(core_clk_i), .dst_rst_ni(core_rst_ni), .evt_o(en_evt)
  );

  ctrl_sync_hs #(.STAGES(SYNC_STAGES)) i_hs_sw (
    .src_clk_i(clk_i), .src_rst_ni(rst_ni), .req_i(sw_req), .busy_o(sw_busy),
    .dst_clk_i(core_clk_i), .dst_rst_ni(core_rst_ni), .evt_o(sw_evt)
  );

  // en_q is held steady while its hand-over is pending, so the core may sample it
  always_ff @(posedge core_clk_i or negedge core_rst_ni)
    if (!core_rst_ni)  core_en_q <= 1'b0;
    else if (sw_evt)   core_en_q <= 1'b0;
    else if (en_evt)   core_en_q <= en_q;

  always_comb begin
    ctrl_o            = '0;
    ctrl_o[BIT_SWRST] = swrst_q;
    ctrl_o[BIT_EN]    = en_q;
    ctrl_o[BIT_CKSEL] = clksel_q;
    status_o            = '0;
    status_o[BIT_SWRST] = swrst_q;
    status_o[BIT_EN]    = en_busy;
  end

  assign clksel_o   = clksel_q;
  assign core_en_o  = core_en_q;
  assign core_rst_o = sw_evt;

  assert_wprot_blocks_R10: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wprot_i && !swrst_q) |=> ($stable(ctrl_o)));

  assert_swrst_precedence_R7: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wprot_i && !swrst_q && wdata_i[BIT_SWRST])
      |=> (swrst_q && $stable(en_q) && $stable(clksel_q)));

  assert_cksel_protect_R6: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && en_q && !swrst_q) |=> $stable(clksel_q));

  assert_en_readback_R3: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wprot_i && !swrst_q && !wdata_i[BIT_SWRST] && !en_busy)
      |=> (en_q == $past(wdata_i[BIT_EN]) && en_busy));

  assert_en_busy_ignore_R5: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && en_busy && !swrst_q) |=> $stable(en_q));

  assert_swrst_ignore_R9: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && swrst_q && sw_busy) |=> ($stable(en_q) && $stable(clksel_q)));

  assert_rst_clears_en_R8: assert property (
    @(posedge core_clk_i) disable iff (!core_rst_ni) sw_evt |=> !core_en_o);
endmodule

// File: tb/test_ctrl_sync_reg.sv
`timescale 1ns/1ps
module test_ctrl_sync_reg;
  logic       clk = 1'b0, core_clk = 1'b0, rst_n = 1'b0, core_rst_n = 1'b0;
  logic       wr_en = 1'b0, wprot = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] ctrl, status;
  logic       clksel, core_en, core_rst;
  int         n_chk = 0, n_fail = 0, pulses = 0, wide = 0;
  logic       prev_pulse = 1'b0;
  bit         done = 1'b0;

  always #2 clk = ~clk;
  always #5 core_clk = ~core_clk;

  ctrl_sync_reg i_ctrl_sync_reg (
    .clk_i(clk), .rst_ni(rst_n), .core_clk_i(core_clk), .core_rst_ni(core_rst_n),
    .wr_en_i(wr_en), .wprot_i(wprot), .wdata_i(wdata),
    .ctrl_o(ctrl), .status_o(status), .clksel_o(clksel),
    .core_en_o(core_en), .core_rst_o(core_rst)
  );

  always @(negedge core_clk) begin
    if (core_rst) pulses++;
    if (core_rst && prev_pulse) wide++;
    prev_pulse = core_rst;
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle(output int cycles, output int mism);
    cycles = 0; mism = 0;
    while (status != 8'h00 && cycles < 40) begin
      @(negedge clk); cycles++;
      if (ctrl[0] !== status[0]) mism++;
    end
  endtask

  task automatic t_reset();
    chk("R1 ctrl", ctrl, 8'h00);
    chk("R1 status", status, 8'h00);
    chk("R1 outs", {5'b0, clksel, core_en, core_rst}, 8'h00);
  endtask

  task automatic t_reserved();
    int c, m;
    bus_write(8'hEC);
    chk("R2 reserved read 0", ctrl, 8'h00);
    wait_idle(c, m);
    chk("R2 ctrl after idle", ctrl, 8'h00);
  endtask

  task automatic t_enable();
    int c, m;
    bus_write(8'h02);
    chk("R3 readback", ctrl, 8'h02);
    chk("R3 busy set", status, 8'h02);
    chk("R4 core not yet", {7'b0, core_en}, 8'h00);
    bus_write(8'h00);
    chk("R5 ignored while busy", ctrl, 8'h02);
    wait_idle(c, m);
    chk("R4 busy cleared in bound", {7'b0, c <= 20}, 8'h01);
    chk("R4 core enable", {7'b0, core_en}, 8'h01);
  endtask

  task automatic t_clksel();
    int c, m;
    bus_write(8'h12);
    chk("R6 protected clksel", {7'b0, clksel}, 8'h00);
    chk("R6 protected ctrl", ctrl, 8'h02);
    wait_idle(c, m);
    bus_write(8'h00);
    wait_idle(c, m);
    chk("R4 core disable", {7'b0, core_en}, 8'h00);
    bus_write(8'h10);
    chk("R6 clksel 32k", {7'b0, clksel}, 8'h01);
    chk("R6 ctrl bit4", ctrl, 8'h10);
    chk("R7 bit0 not set by 0", {7'b0, ctrl[0]}, 8'h00);
    wait_idle(c, m);
  endtask

  task automatic t_swrst();
    int c, m, p0;
    bus_write(8'h12);
    wait_idle(c, m);
    chk("R4 core enable again", {7'b0, core_en}, 8'h01);
    p0 = pulses;
    bus_write(8'h01);
    chk("R7 precedence ctrl", ctrl, 8'h13);
    chk("R7 busy bit0", status, 8'h01);
    bus_write(8'h00);
    chk("R9 ignored during reset", ctrl, 8'h13);
    wait_idle(c, m);
    chk("R7 bit and flag clear together", m[7:0], 8'h00);
    chk("R8 ctrl zero", ctrl, 8'h00);
    chk("R8 clksel fast", {7'b0, clksel}, 8'h00);
    chk("R8 core enable off", {7'b0, core_en}, 8'h00);
    repeat (10) @(negedge clk);
    chk("R8 one pulse", 8'(pulses - p0), 8'h01);
    chk("R8 pulse width", 8'(wide), 8'h00);
  endtask

  task automatic t_wprot();
    int c, m;
    wprot = 1'b1;
    bus_write(8'h12);
    chk("R10 ctrl", ctrl, 8'h00);
    chk("R10 status", status, 8'h00);
    bus_write(8'h01);
    chk("R10 swrst blocked", ctrl, 8'h00);
    repeat (20) @(negedge clk);
    chk("R10 core", {6'b0, core_en, clksel}, 8'h00);
    wprot = 1'b0;
    wait_idle(c, m);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; core_rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reserved();
    t_enable();
    t_clksel();
    t_swrst();
    t_wprot();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule